// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side controller for a serial sampling ADC. The ADC uses one line as both its conversion strobe and its frame select. The sequencer keeps that strobe high for a programmable conversion wait, then pulls it low. After a setup delay it runs exactly sixteen serial clock periods, then raises the strobe again so that the next conversion starts. During each frame it does two things. It sends a two-bit channel setting to the ADC on the first two rising clock edges. It also collects the sixteen result bits that the ADC returns, most significant bit first.

The serial clock is derived from the system clock. Every half period, the setup delay, the hold after the last rising edge and the conversion wait are parameters counted in system clock cycles. A frame starts on a start request, or continuously while free-run is held high. A result leaves the block as a one-cycle valid strobe. The ADC's multiplexer takes effect one frame late, so each result is tagged with the channel that was programmed in the frame before it.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is active and right after it: convOut is 1, sckOut is 0, sdiOut is 0, busy is 0, resultValid is 0 and resultChan is 0.
- R2: convOut stays high for at least CONV_WAIT system cycles. This holds after reset and after every frame. When a request is already waiting, convOut stays high for exactly CONV_WAIT cycles.
- R3: After convOut falls, the first rising edge of sckOut comes exactly SETUP_CYC system cycles later.
- R4: Each frame has exactly 16 rising edges of sckOut. Each high phase and each low phase inside the frame lasts DIV_HALF cycles. sckOut is low whenever convOut is high.
- R5: convOut rises exactly DIV_HALF + HOLD_CYC cycles after the last rising edge of sckOut in the frame.
- R6: chanSel is latched in the cycle that convOut falls. sdiOut carries chanSel[1] at the first rising edge of sckOut and chanSel[0] at the second. It carries 0 at rising edges 3 to 16. sdiOut changes only when convOut falls or sckOut falls.
- R7: sdoIn is sampled once per serial clock period, in the last system cycle of the high phase. The 16 samples form resultData with the first sample in bit 15.
- R8: resultValid is a single-cycle pulse. It is high in exactly the cycle in which convOut has just risen, and resultData is valid while it is high.
- R9: resultChan, given with each result, is the chanSel value latched at the start of the previous frame. For the first frame after reset it is 0.
- R10: busy is high from the cycle convOut falls until the result is delivered, and it is low in the cycle resultValid is high.
- R11: A one-cycle start pulse starts exactly one frame. If the pulse comes while a frame or the conversion wait is still running, it is held and used as soon as the wait ends. Without start or free-run, no frame begins.
- R12: While freeRun is high, frames follow one another with no idle time beyond the conversion wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame |
| freeRun | input | 1 | Run frames back to back while high |
| chanSel | input | 2 | Channel to program during the next frame |
| sdoIn | input | 1 | Serial data from the ADC |
| convOut | output | 1 | Conversion strobe and frame select to the ADC |
| sckOut | output | 1 | Serial clock to the ADC |
| sdiOut | output | 1 | Channel setting bits to the ADC |
| busy | output | 1 | Frame in progress |
| resultValid | output | 1 | One-cycle strobe for a new result |
| resultData | output | 16 | Assembled conversion result |
| resultChan | output | 2 | Channel that produced resultData |

## Verification
The hardest case to reach is a start request that arrives while a frame is still shifting. Such a request must be held and used at the first cycle the conversion wait allows, without starting an extra frame. The stimulus drives this case by pulsing start a few cycles after busy rises. It then checks that the next strobe-high interval is exactly the wait length, and that no third frame follows. The one-frame lag of the channel tag is covered by a bench ADC model. The model switches its mux only at the end of each frame and encodes the mux channel into the top bits of its word. A channel sequence that changes on every frame then shows any misalignment in both resultData and resultChan.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  // Strobes from the control FSM to the shift datapath, one cycle each.
  typedef struct packed {
    logic loadCfg;    // frame launch: latch channel, arm setting shifter
    logic shiftCfg;   // serial clock falls: advance setting bit
    logic sampleSdo;  // last cycle of high phase: take one result bit
    logic finish;     // strobe rises: publish result
  } seq_strobe_t;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DIV_HALF   = 7,
  parameter int SETUP_CYC  = 6,
  parameter int CONV_WAIT  = 467,
  parameter int HOLD_CYC   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        freeRun,
  output logic        convOut,
  output logic        sckOut,
  output logic        busy,
  output seq_strobe_t strb
);

  localparam int MAX_AB = (CONV_WAIT > SETUP_CYC) ? CONV_WAIT : SETUP_CYC;
  localparam int MAX_CD = (DIV_HALF > HOLD_CYC) ? DIV_HALF : HOLD_CYC;
  localparam int MAX_V  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_V + 1);
  localparam int BIT_W  = $clog2(FRAME_BITS);

  seq_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitIdx;
  logic               pending;

  logic waitDone, launch, setupEnd, phaseEnd, holdEnd, lastBit, wantFrame;

  // One shared down-the-line counter serves every timed interval.
  assign waitDone  = (cnt >= CNT_W'(CONV_WAIT - 1));
  assign wantFrame = start | freeRun | pending;
  assign launch    = (state == ST_WAIT) && waitDone && wantFrame;
  assign setupEnd  = (state == ST_SETUP) && (cnt == CNT_W'(SETUP_CYC - 1));
  assign phaseEnd  = (state == ST_SHIFT) && (cnt == CNT_W'(DIV_HALF - 1));
  assign holdEnd   = (state == ST_HOLD) && (cnt == CNT_W'(HOLD_CYC - 1));
  assign lastBit   = (bitIdx == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    strb.loadCfg   = launch;
    strb.sampleSdo = phaseEnd && sckOut;
    strb.shiftCfg  = phaseEnd && sckOut;
    strb.finish    = holdEnd;
  end

  // A start that cannot be honoured yet is remembered until launch.
  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= (pending | start) & ~launch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      cnt     <= '0;
      bitIdx  <= '0;
      convOut <= 1'b1;
      sckOut  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (launch) begin
            state   <= ST_SETUP;
            cnt     <= '0;
            convOut <= 1'b0;
            busy    <= 1'b1;
          end else if (!waitDone) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SETUP: begin
          if (setupEnd) begin
            state  <= ST_SHIFT;
            cnt    <= '0;
            bitIdx <= '0;
            sckOut <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            cnt <= '0;
            if (sckOut) begin
              sckOut <= 1'b0;
              if (lastBit) state <= ST_HOLD;
            end else begin
              sckOut <= 1'b1;
              bitIdx <= bitIdx + BIT_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (holdEnd) begin
            state   <= ST_WAIT;
            cnt     <= '0;
            convOut <= 1'b1;
            busy    <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // Independent measure of strobe-high time for the wait check.
  logic [CNT_W-1:0] chkHigh;
  always_ff @(posedge clk) begin
    if (!rstN)        chkHigh <= '0;
    else if (!convOut) chkHigh <= '0;
    else if (chkHigh < CNT_W'(CONV_WAIT)) chkHigh <= chkHigh + CNT_W'(1);
  end

  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rstN)
    convOut |-> !sckOut);

  a_r2_wait_met: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convOut) |-> (chkHigh >= CNT_W'(CONV_WAIT)));

  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $fell(convOut));

endmodule

// File: rtl/adc_seq_datapath.sv
`timescale 1ns/1ps
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CFG_BITS   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           strb,
  input  logic [CFG_BITS-1:0]   chanSel,
  input  logic                  sdoIn,
  output logic                  sdiOut,
  output logic                  resultValid,
  output logic [FRAME_BITS-1:0] resultData,
  output logic [CFG_BITS-1:0]   resultChan
);

  logic [CFG_BITS-1:0]   cfgShift;
  logic [CFG_BITS-1:0]   lastChan;
  logic [CFG_BITS-1:0]   frameChan;
  logic [FRAME_BITS-1:0] capShift;

  // Setting shifter: MSB first, zeros fill behind it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgShift  <= '0;
      lastChan  <= '0;
      frameChan <= '0;
    end else if (strb.loadCfg) begin
      cfgShift  <= chanSel;
      frameChan <= lastChan;
      lastChan  <= chanSel;
    end else if (strb.shiftCfg) begin
      cfgShift  <= cfgShift << 1;
    end
  end

  assign sdiOut = cfgShift[CFG_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN)               capShift <= '0;
    else if (strb.sampleSdo) capShift <= {capShift[FRAME_BITS-2:0], sdoIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultData  <= '0;
      resultChan  <= '0;
    end else begin
      resultValid <= strb.finish;
      if (strb.finish) begin
        resultData <= capShift;
        resultChan <= frameChan;
      end
    end
  end

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CFG_BITS   = 2,
  parameter int DIV_HALF   = 7,
  parameter int SETUP_CYC  = 6,
  parameter int CONV_WAIT  = 467,
  parameter int HOLD_CYC   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  freeRun,
  input  logic [CFG_BITS-1:0]   chanSel,
  input  logic                  sdoIn,
  output logic                  convOut,
  output logic                  sckOut,
  output logic                  sdiOut,
  output logic                  busy,
  output logic                  resultValid,
  output logic [FRAME_BITS-1:0] resultData,
  output logic [CFG_BITS-1:0]   resultChan
);

  seq_strobe_t strb;

  adc_seq_ctrl #(
    .FRAME_BITS(FRAME_BITS), .DIV_HALF(DIV_HALF), .SETUP_CYC(SETUP_CYC),
    .CONV_WAIT(CONV_WAIT), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .freeRun(freeRun),
    .convOut(convOut), .sckOut(sckOut), .busy(busy), .strb(strb)
  );

  adc_seq_datapath #(
    .FRAME_BITS(FRAME_BITS), .CFG_BITS(CFG_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanSel(chanSel), .sdoIn(sdoIn),
    .sdiOut(sdiOut), .resultValid(resultValid), .resultData(resultData),
    .resultChan(resultChan)
  );

  a_r6_sdi_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdiOut) |-> ($fell(sckOut) || $fell(convOut)));

endmodule

// File: tb/tb_adc_frame_seq.sv
`timescale 1ns/1ps
module tb_adc_frame_seq;

  localparam int DIV_HALF  = 2;
  localparam int SETUP_CYC = 3;
  localparam int CONV_WAIT = 10;
  localparam int HOLD_CYC  = 2;

  logic clk = 0, rstN = 0, start = 0, freeRun = 0, sdoIn = 0;
  logic [1:0] chanSel = 0;
  logic convOut, sckOut, sdiOut, busy, resultValid;
  logic [15:0] resultData;
  logic [1:0] resultChan;

  adc_frame_seq #(.DIV_HALF(DIV_HALF), .SETUP_CYC(SETUP_CYC),
                  .CONV_WAIT(CONV_WAIT), .HOLD_CYC(HOLD_CYC)) dut (
    .clk(clk), .rstN(rstN), .start(start), .freeRun(freeRun),
    .chanSel(chanSel), .sdoIn(sdoIn), .convOut(convOut), .sckOut(sckOut),
    .sdiOut(sdiOut), .busy(busy), .resultValid(resultValid),
    .resultData(resultData), .resultChan(resultChan));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] chanSeq(input int f);
    return 2'((f * 3 + 1) % 4);
  endfunction

  function automatic logic [15:0] mkWord(input int f, input logic [1:0] ch);
    logic [13:0] low;
    if (f == 1)      low = '0;
    else if (f == 2) low = '1;
    else             low = 14'(f * 1237 + 91);
    return {ch, low};
  endfunction

  // ADC model: mux takes the setting received in the previous frame.
  int mFrame = 0, mBit = 0, mRise = 0;
  bit mActive = 0, mExtra = 0;
  logic [1:0] mMux = 0, mCfg = 0;
  logic [15:0] mWord = 0;
  logic [15:0] sentWord [0:63];
  logic [1:0]  rxCfg    [0:63];
  bit          rxExtra  [0:63];
  int          rxRises  [0:63];

  always @(negedge convOut) if (rstN) begin
    mActive = 1; mWord = mkWord(mFrame, mMux); sentWord[mFrame] = mWord;
    mBit = 15; mRise = 0; mCfg = 0; mExtra = 0;
    #2 sdoIn = mWord[15];
  end
  always @(negedge sckOut) if (mActive) begin
    mBit--;
    #2 sdoIn = (mBit >= 0) ? mWord[mBit[3:0]] : 1'b0;
  end
  always @(posedge sckOut) if (mActive) begin
    mRise++;
    if (mRise <= 2) mCfg = {mCfg[0], sdiOut};
    else if (sdiOut) mExtra = 1;
  end
  always @(posedge convOut) if (mActive) begin
    mActive = 0; rxCfg[mFrame] = mCfg; rxExtra[mFrame] = mExtra;
    rxRises[mFrame] = mRise; mMux = mCfg; mFrame++;
  end

  // Channel input follows the sequence, changed well after each launch edge.
  int nextF = 1;
  initial forever begin
    @(negedge convOut);
    #6 chanSel = chanSeq(nextF);
    nextF++;
  end

  // Timing monitor, sampled at the falling system clock edge.
  logic prevConv = 1, prevSck = 0;
  int highCnt = 0, sinceFall = 0, sinceRise = 0, phaseLen = 0, rises = 0;
  int lastHighLen = 0, frameFalls = 0, resultsSeen = 0;
  bit busyBad = 0, sckIdleBad = 0, validBad = 0;
  logic [1:0] reqChan [0:63];

  always @(negedge clk) if (rstN && !done) begin
    if (convOut) begin
      if (!prevConv) begin
        check(sinceRise == DIV_HALF + HOLD_CYC, "R5", "rise-to-strobe cycles",
              sinceRise, DIV_HALF + HOLD_CYC);
        check(resultValid, "R8", "valid with strobe rise", resultValid, 1);
        highCnt = 1;
      end else begin
        highCnt++;
        if (resultValid) validBad = 1;
      end
      if (sckOut) sckIdleBad = 1;
      if (busy) busyBad = 1;
    end else begin
      if (prevConv) begin
        check(highCnt >= CONV_WAIT, "R2", "strobe high cycles", highCnt, CONV_WAIT);
        lastHighLen = highCnt;
        reqChan[frameFalls] = chanSel;
        frameFalls++;
        sinceFall = 1; rises = 0;
      end else begin
        if (sckOut && !prevSck) begin
          if (rises == 0)
            check(sinceFall == SETUP_CYC, "R3", "setup cycles", sinceFall, SETUP_CYC);
          else
            check(phaseLen == DIV_HALF, "R4", "low phase", phaseLen, DIV_HALF);
          rises++; phaseLen = 1; sinceRise = 1;
        end else if (!sckOut && prevSck) begin
          check(phaseLen == DIV_HALF, "R4", "high phase", phaseLen, DIV_HALF);
          phaseLen = 1; sinceRise++;
        end else begin
          phaseLen++; sinceRise++;
        end
        sinceFall++;
      end
      if (!busy) busyBad = 1;
      if (resultValid) validBad = 1;
    end
    if (resultValid) begin
      check(resultData == sentWord[resultsSeen], "R7", "result word",
            resultData, sentWord[resultsSeen]);
      check(resultChan == ((resultsSeen == 0) ? 2'd0 : reqChan[resultsSeen-1]),
            "R9", "channel tag", resultChan,
            (resultsSeen == 0) ? 0 : reqChan[resultsSeen-1]);
      check(rxCfg[resultsSeen] == reqChan[resultsSeen], "R6", "setting bits",
            rxCfg[resultsSeen], reqChan[resultsSeen]);
      check(!rxExtra[resultsSeen], "R6", "trailing sdi bits", rxExtra[resultsSeen], 0);
      check(rxRises[resultsSeen] == 16, "R4", "rising edges", rxRises[resultsSeen], 16);
      check(!busy, "R10", "busy at valid", busy, 0);
      check(!busyBad, "R10", "busy window", busyBad, 0);
      check(!sckIdleBad, "R4", "sck idle while strobe high", sckIdleBad, 0);
      check(!validBad, "R8", "stray valid", validBad, 0);
      busyBad = 0; sckIdleBad = 0; validBad = 0;
      resultsSeen++;
    end
    prevConv = convOut; prevSck = sckOut;
  end

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", resultsSeen, 14);
      finishRun();
    end
  end

  initial begin
    chanSel = chanSeq(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(convOut == 1 && sckOut == 0 && sdiOut == 0, "R1", "lines in reset",
          {convOut, sckOut, sdiOut}, 3'b100);
    check(busy == 0 && resultValid == 0 && resultChan == 0, "R1", "status in reset",
          {busy, resultValid, resultChan}, 0);
    rstN = 1;
    @(negedge clk);
    check(convOut == 1 && busy == 0, "R1", "after reset", {convOut, busy}, 2'b10);
    repeat (40) @(negedge clk);
    check(frameFalls == 0, "R11", "no frame without request", frameFalls, 0);
    start = 1; @(negedge clk); start = 0;
    wait (busy == 1);
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait (frameFalls == 2);
    @(negedge clk);
    check(lastHighLen == CONV_WAIT, "R11", "held start launch gap", lastHighLen, CONV_WAIT);
    wait (resultsSeen == 2);
    repeat (60) @(negedge clk);
    check(frameFalls == 2, "R11", "one frame per request", frameFalls, 2);
    freeRun = 1;
    for (int k = 4; k <= 14; k++) begin
      wait (frameFalls == k);
      @(negedge clk);
      check(lastHighLen == CONV_WAIT, "R12", "free-run gap", lastHighLen, CONV_WAIT);
    end
    freeRun = 0;
    wait (resultsSeen == frameFalls);
    repeat (60) @(negedge clk);
    check(frameFalls == resultsSeen, "R12", "stops when free-run drops",
          frameFalls, resultsSeen);
    finishRun();
  end

endmodule